// File: doc/BRIEF.md
# Port Transfer Instruction Executor

This block carries out the port input and output instructions of a 4-bit microcontroller core. It receives the instruction stream one byte per cycle. For each port instruction it issues port read or write strobes and moves a 4-bit value in one direction. One side is always a port. The other side is the accumulator, the extra E register or the memory nibble addressed by HL. It also raises the register, memory and zero-flag write enables that the core commits on the next clock edge.

A port is chosen in one of three ways:
- It can be fixed as port 0.
- It can come from the low nibble of the data pointer, supplied on an input.
- It can come from a 4-bit immediate in the second byte of a two-byte instruction.

A paired form transfers E with port 4 and the accumulator with port 5, both in the same cycle. It uses two read lanes or two write lanes. Port reads are combinational: the block drives an index, and the port logic returns the pin value in the same cycle. The block's only state is the pending prefix of a two-byte instruction.

Top module: `port_xfer_exec`

## Requirements
- R1: After reset there is no pending prefix. With `op_valid_i` low, `done_o`, every port strobe and every write enable are 0.
- R2: Byte 0x20 reads port 0 on lane A and writes the value to the accumulator (`ac_we_o`, `ac_wdata_o`). It updates the zero flag and completes in the same cycle.
- R3: Byte 0x26 reads the port indexed by `dp_lo_i` into the accumulator and updates the zero flag. Byte 0x19 reads that port into the memory nibble (`mem_we_o`, `mem_wdata_o`) and does not touch the accumulator.
- R4: Byte 0x25 writes `ac_i` to port `dp_lo_i` on lane A. Byte 0x1A writes `mem_rdata_i` to that port. Neither form issues a port read.
- R5: Prefix byte 0xB4 (direct input) or 0xB5 (direct output) causes no strobe and no `done_o`. The next accepted byte completes the instruction, with its low nibble as the port index and its upper nibble ignored. Direct input loads the accumulator and updates the zero flag. Direct output writes `ac_i` to the port.
- R6: After prefix byte 0xF1, a second byte of 0xBA reads port 4 into E on lane A and port 5 into the accumulator on lane B, in one cycle. A second byte of 0xBB writes `e_i` to port 4 on lane A and `ac_i` to port 5 on lane B, in one cycle.
- R7: `zf_we_o` is high only together with `ac_we_o`. `zf_o` is 1 exactly when the written accumulator value is 0000.
- R8: Output forms and the input-to-memory form keep `zf_we_o` low.
- R9: `done_o` is high in the cycle that completes an instruction, and only then.
  - An unrecognized single-byte opcode, or a second byte after 0xF1 other than 0xBA or 0xBB, completes with no strobe and no write.
  - Prefix bytes and idle cycles give `done_o` = 0.
- R10: A pending prefix is held through cycles where `op_valid_i` is low. The next valid byte is taken as its second byte.
- R11: Port reads and port writes never occur in the same cycle. Lane B is used only by the paired forms, with index 5 on lane B and index 4 on lane A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Instruction byte present this cycle |
| op_byte_i | input | 8 | Instruction byte |
| dp_lo_i | input | 4 | Low data-pointer nibble (indirect port index) |
| ac_i | input | 4 | Current accumulator |
| e_i | input | 4 | Current E register |
| mem_rdata_i | input | 4 | Memory nibble addressed by HL |
| rd_a_o | output | 1 | Port read strobe, lane A |
| rd_a_idx_o | output | 4 | Port index, read lane A |
| rd_a_data_i | input | 4 | Port value returned on lane A |
| rd_b_o | output | 1 | Port read strobe, lane B |
| rd_b_idx_o | output | 4 | Port index, read lane B |
| rd_b_data_i | input | 4 | Port value returned on lane B |
| wr_a_o | output | 1 | Port write strobe, lane A |
| wr_a_idx_o | output | 4 | Port index, write lane A |
| wr_a_data_o | output | 4 | Port write data, lane A |
| wr_b_o | output | 1 | Port write strobe, lane B |
| wr_b_idx_o | output | 4 | Port index, write lane B |
| wr_b_data_o | output | 4 | Port write data, lane B |
| ac_we_o | output | 1 | Accumulator write enable |
| ac_wdata_o | output | 4 | Accumulator write data |
| e_we_o | output | 1 | E register write enable |
| e_wdata_o | output | 4 | E register write data |
| mem_we_o | output | 1 | Memory nibble write enable |
| mem_wdata_o | output | 4 | Memory nibble write data |
| zf_we_o | output | 1 | Zero flag write enable |
| zf_o | output | 1 | New zero flag value |
| done_o | output | 1 | Instruction completes this cycle |

## Verification
The assertions assume that `op_valid_i` is low during reset and that port read data arrives in the same cycle as the index. They also assume that a second byte always follows its prefix with no intervening reset. The bench drives bytes only between clock edges and holds `op_valid_i` low while reset is active. It models the ports as a 16-entry array that is read combinationally through the lane indices. Expected results come from that array and from the register values the bench drives. Prefix stalls, ignored upper immediate bits and unknown second bytes are each exercised explicitly.

// File: rtl/port_xfer_pkg.sv
package port_xfer_pkg;
  // single-byte opcodes
  localparam logic [7:0] BYTE_IN0_AC  = 8'h20;
  localparam logic [7:0] BYTE_IND_AC  = 8'h26;
  localparam logic [7:0] BYTE_IND_MEM = 8'h19;
  localparam logic [7:0] BYTE_OUT_AC  = 8'h25;
  localparam logic [7:0] BYTE_OUT_MEM = 8'h1A;
  // prefixes of two-byte forms
  localparam logic [7:0] BYTE_PFX_DIN  = 8'hB4;
  localparam logic [7:0] BYTE_PFX_DOUT = 8'hB5;
  localparam logic [7:0] BYTE_PFX_PAIR = 8'hF1;
  // second bytes of the paired form
  localparam logic [7:0] BYTE_PAIR_IN  = 8'hBA;
  localparam logic [7:0] BYTE_PAIR_OUT = 8'hBB;

  typedef enum logic [1:0] {
    PEND_NONE, PEND_DIN, PEND_DOUT, PEND_PAIR
  } pend_e;

  typedef enum logic [3:0] {
    OP_NONE,      // nothing completes this cycle
    OP_NOP,       // completes with no effect
    OP_IN0_AC,
    OP_IND_AC,
    OP_IND_MEM,
    OP_OUT_AC,
    OP_OUT_MEM,
    OP_DIR_IN,
    OP_DIR_OUT,
    OP_PAIR_IN,
    OP_PAIR_OUT
  } op_e;
endpackage

// File: rtl/port_xfer_decode.sv
module port_xfer_decode
  import port_xfer_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  input  pend_e            pend_i,
  output pend_e            pend_nxt_o,
  output op_e              op_o,
  output logic [IDX_W-1:0] imm_o
);
  assign imm_o = byte_i[IDX_W-1:0];

  always_comb begin
    op_o       = OP_NONE;
    pend_nxt_o = pend_i;
    if (valid_i) begin
      if (pend_i == PEND_NONE) begin
        unique case (byte_i)
          BYTE_IN0_AC:   op_o = OP_IN0_AC;
          BYTE_IND_AC:   op_o = OP_IND_AC;
          BYTE_IND_MEM:  op_o = OP_IND_MEM;
          BYTE_OUT_AC:   op_o = OP_OUT_AC;
          BYTE_OUT_MEM:  op_o = OP_OUT_MEM;
          BYTE_PFX_DIN:  pend_nxt_o = PEND_DIN;
          BYTE_PFX_DOUT: pend_nxt_o = PEND_DOUT;
          BYTE_PFX_PAIR: pend_nxt_o = PEND_PAIR;
          default:       op_o = OP_NOP;
        endcase
      end else begin
        pend_nxt_o = PEND_NONE;
        unique case (pend_i)
          PEND_DIN:  op_o = OP_DIR_IN;
          PEND_DOUT: op_o = OP_DIR_OUT;
          default: begin
            if (byte_i == BYTE_PAIR_IN)       op_o = OP_PAIR_IN;
            else if (byte_i == BYTE_PAIR_OUT) op_o = OP_PAIR_OUT;
            else                              op_o = OP_NOP;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/port_xfer_seq.sv
module port_xfer_seq
  import port_xfer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pend_e pend_nxt_i,
  output pend_e pend_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q_o <= PEND_NONE;
    else         pend_q_o <= pend_nxt_i;
  end
endmodule

// File: rtl/port_xfer_route.sv
module port_xfer_route
  import port_xfer_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int IDX_W = 4,
  parameter int PAIR_LO_IDX = 4,
  parameter int PAIR_HI_IDX = 5
) (
  input  op_e              op_i,
  input  logic [IDX_W-1:0] imm_i,
  input  logic [IDX_W-1:0] dp_lo_i,
  input  logic [NIB_W-1:0] ac_i,
  input  logic [NIB_W-1:0] e_i,
  input  logic [NIB_W-1:0] mem_rdata_i,
  input  logic [NIB_W-1:0] rd_a_data_i,
  input  logic [NIB_W-1:0] rd_b_data_i,
  output logic             rd_a_o,
  output logic [IDX_W-1:0] rd_a_idx_o,
  output logic             rd_b_o,
  output logic [IDX_W-1:0] rd_b_idx_o,
  output logic             wr_a_o,
  output logic [IDX_W-1:0] wr_a_idx_o,
  output logic [NIB_W-1:0] wr_a_data_o,
  output logic             wr_b_o,
  output logic [IDX_W-1:0] wr_b_idx_o,
  output logic [NIB_W-1:0] wr_b_data_o,
  output logic             ac_we_o,
  output logic [NIB_W-1:0] ac_wdata_o,
  output logic             e_we_o,
  output logic [NIB_W-1:0] e_wdata_o,
  output logic             mem_we_o,
  output logic [NIB_W-1:0] mem_wdata_o,
  output logic             zf_we_o,
  output logic             zf_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] IDX_LO   = IDX_W'(PAIR_LO_IDX);
  localparam logic [IDX_W-1:0] IDX_HI   = IDX_W'(PAIR_HI_IDX);
  localparam logic [IDX_W-1:0] IDX_ZERO = '0;

  always_comb begin
    rd_a_o = 1'b0; rd_a_idx_o = '0;
    rd_b_o = 1'b0; rd_b_idx_o = '0;
    wr_a_o = 1'b0; wr_a_idx_o = '0; wr_a_data_o = '0;
    wr_b_o = 1'b0; wr_b_idx_o = '0; wr_b_data_o = '0;
    ac_we_o = 1'b0; ac_wdata_o = '0;
    e_we_o = 1'b0;  e_wdata_o = '0;
    mem_we_o = 1'b0; mem_wdata_o = '0;
    unique case (op_i)
      OP_IN0_AC: begin
        rd_a_o = 1'b1; rd_a_idx_o = IDX_ZERO;
        ac_we_o = 1'b1; ac_wdata_o = rd_a_data_i;
      end
      OP_IND_AC: begin
        rd_a_o = 1'b1; rd_a_idx_o = dp_lo_i;
        ac_we_o = 1'b1; ac_wdata_o = rd_a_data_i;
      end
      OP_DIR_IN: begin
        rd_a_o = 1'b1; rd_a_idx_o = imm_i;
        ac_we_o = 1'b1; ac_wdata_o = rd_a_data_i;
      end
      OP_IND_MEM: begin
        rd_a_o = 1'b1; rd_a_idx_o = dp_lo_i;
        mem_we_o = 1'b1; mem_wdata_o = rd_a_data_i;
      end
      OP_OUT_AC: begin
        wr_a_o = 1'b1; wr_a_idx_o = dp_lo_i; wr_a_data_o = ac_i;
      end
      OP_OUT_MEM: begin
        wr_a_o = 1'b1; wr_a_idx_o = dp_lo_i; wr_a_data_o = mem_rdata_i;
      end
      OP_DIR_OUT: begin
        wr_a_o = 1'b1; wr_a_idx_o = imm_i; wr_a_data_o = ac_i;
      end
      OP_PAIR_IN: begin
        rd_a_o = 1'b1; rd_a_idx_o = IDX_LO;
        rd_b_o = 1'b1; rd_b_idx_o = IDX_HI;
        e_we_o = 1'b1;  e_wdata_o  = rd_a_data_i;
        ac_we_o = 1'b1; ac_wdata_o = rd_b_data_i;
      end
      OP_PAIR_OUT: begin
        wr_a_o = 1'b1; wr_a_idx_o = IDX_LO; wr_a_data_o = e_i;
        wr_b_o = 1'b1; wr_b_idx_o = IDX_HI; wr_b_data_o = ac_i;
      end
      default: ;
    endcase
  end

  // every accumulator load from a port also sets the zero flag
  assign zf_we_o = ac_we_o;
  assign zf_o    = ac_we_o && (ac_wdata_o == '0);
  assign done_o  = (op_i != OP_NONE);
endmodule

// File: rtl/port_xfer_exec.sv
module port_xfer_exec
  import port_xfer_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int PORT_CNT = 16,
  parameter int PAIR_LO_IDX = 4,
  parameter int PAIR_HI_IDX = 5,
  localparam int IDX_W = $clog2(PORT_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [7:0]       op_byte_i,
  input  logic [IDX_W-1:0] dp_lo_i,
  input  logic [NIB_W-1:0] ac_i,
  input  logic [NIB_W-1:0] e_i,
  input  logic [NIB_W-1:0] mem_rdata_i,
  output logic             rd_a_o,
  output logic [IDX_W-1:0] rd_a_idx_o,
  input  logic [NIB_W-1:0] rd_a_data_i,
  output logic             rd_b_o,
  output logic [IDX_W-1:0] rd_b_idx_o,
  input  logic [NIB_W-1:0] rd_b_data_i,
  output logic             wr_a_o,
  output logic [IDX_W-1:0] wr_a_idx_o,
  output logic [NIB_W-1:0] wr_a_data_o,
  output logic             wr_b_o,
  output logic [IDX_W-1:0] wr_b_idx_o,
  output logic [NIB_W-1:0] wr_b_data_o,
  output logic             ac_we_o,
  output logic [NIB_W-1:0] ac_wdata_o,
  output logic             e_we_o,
  output logic [NIB_W-1:0] e_wdata_o,
  output logic             mem_we_o,
  output logic [NIB_W-1:0] mem_wdata_o,
  output logic             zf_we_o,
  output logic             zf_o,
  output logic             done_o
);
  pend_e            pend_q, pend_nxt;
  op_e              op;
  logic [IDX_W-1:0] imm;

  port_xfer_decode #(.IDX_W(IDX_W)) u_decode (
    .valid_i(op_valid_i), .byte_i(op_byte_i), .pend_i(pend_q),
    .pend_nxt_o(pend_nxt), .op_o(op), .imm_o(imm)
  );

  port_xfer_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_nxt_i(pend_nxt), .pend_q_o(pend_q)
  );

  port_xfer_route #(
    .NIB_W(NIB_W), .IDX_W(IDX_W),
    .PAIR_LO_IDX(PAIR_LO_IDX), .PAIR_HI_IDX(PAIR_HI_IDX)
  ) u_route (
    .op_i(op), .imm_i(imm), .dp_lo_i(dp_lo_i), .ac_i(ac_i), .e_i(e_i),
    .mem_rdata_i(mem_rdata_i), .rd_a_data_i(rd_a_data_i), .rd_b_data_i(rd_b_data_i),
    .rd_a_o(rd_a_o), .rd_a_idx_o(rd_a_idx_o), .rd_b_o(rd_b_o), .rd_b_idx_o(rd_b_idx_o),
    .wr_a_o(wr_a_o), .wr_a_idx_o(wr_a_idx_o), .wr_a_data_o(wr_a_data_o),
    .wr_b_o(wr_b_o), .wr_b_idx_o(wr_b_idx_o), .wr_b_data_o(wr_b_data_o),
    .ac_we_o(ac_we_o), .ac_wdata_o(ac_wdata_o), .e_we_o(e_we_o), .e_wdata_o(e_wdata_o),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .zf_we_o(zf_we_o), .zf_o(zf_o), .done_o(done_o)
  );
endmodule

// File: rtl/port_xfer_exec_chk.sv
module port_xfer_exec_chk #(
  parameter int NIB_W = 4,
  parameter int IDX_W = 4,
  parameter int PAIR_LO_IDX = 4,
  parameter int PAIR_HI_IDX = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic             rd_a_o,
  input logic [IDX_W-1:0] rd_a_idx_o,
  input logic             rd_b_o,
  input logic [IDX_W-1:0] rd_b_idx_o,
  input logic             wr_a_o,
  input logic [IDX_W-1:0] wr_a_idx_o,
  input logic             wr_b_o,
  input logic [IDX_W-1:0] wr_b_idx_o,
  input logic             ac_we_o,
  input logic [NIB_W-1:0] ac_wdata_o,
  input logic             e_we_o,
  input logic             mem_we_o,
  input logic             zf_we_o,
  input logic             zf_o,
  input logic             done_o
);
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((rd_a_o || rd_b_o) && (wr_a_o || wr_b_o))); // R11
  AST_RD_B_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_o |-> (rd_a_o && rd_a_idx_o == IDX_W'(PAIR_LO_IDX) && rd_b_idx_o == IDX_W'(PAIR_HI_IDX) && e_we_o)); // R6
  AST_WR_B_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_b_o |-> (wr_a_o && wr_a_idx_o == IDX_W'(PAIR_LO_IDX) && wr_b_idx_o == IDX_W'(PAIR_HI_IDX))); // R6
  AST_ZF_WITH_AC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zf_we_o |-> (ac_we_o && (zf_o == (ac_wdata_o == '0)))); // R7
  AST_NO_ZF_ON_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_o || mem_we_o) |-> !zf_we_o); // R8
  AST_EFFECT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_o || wr_a_o || ac_we_o || e_we_o || mem_we_o) |-> done_o); // R9
  AST_DONE_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> op_valid_i); // R9
  AST_PREFIX_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !done_o) |=> (!op_valid_i || done_o)); // R10
endmodule

bind port_xfer_exec port_xfer_exec_chk #(
  .NIB_W(NIB_W), .IDX_W(IDX_W), .PAIR_LO_IDX(PAIR_LO_IDX), .PAIR_HI_IDX(PAIR_HI_IDX)
) u_chk (.*);

// File: tb/port_xfer_exec_tb.sv
module port_xfer_exec_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = '0;
  logic [3:0] dp_lo = '0, ac = '0, e_reg = '0, mem_rd = '0;
  logic [3:0] ports [16];

  logic       rd_a, rd_b, wr_a, wr_b, ac_we, e_we, mem_we, zf_we, zf, done;
  logic [3:0] rd_a_idx, rd_b_idx, wr_a_idx, wr_b_idx;
  logic [3:0] rd_a_data, rd_b_data, wr_a_data, wr_b_data;
  logic [3:0] ac_wdata, e_wdata, mem_wdata;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_a_data = ports[rd_a_idx];
  assign rd_b_data = ports[rd_b_idx];

  port_xfer_exec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_byte_i(op_byte),
    .dp_lo_i(dp_lo), .ac_i(ac), .e_i(e_reg), .mem_rdata_i(mem_rd),
    .rd_a_o(rd_a), .rd_a_idx_o(rd_a_idx), .rd_a_data_i(rd_a_data),
    .rd_b_o(rd_b), .rd_b_idx_o(rd_b_idx), .rd_b_data_i(rd_b_data),
    .wr_a_o(wr_a), .wr_a_idx_o(wr_a_idx), .wr_a_data_o(wr_a_data),
    .wr_b_o(wr_b), .wr_b_idx_o(wr_b_idx), .wr_b_data_o(wr_b_data),
    .ac_we_o(ac_we), .ac_wdata_o(ac_wdata), .e_we_o(e_we), .e_wdata_o(e_wdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .zf_we_o(zf_we), .zf_o(zf), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // drive one cycle of input between edges, settle, leave for checks
  task automatic step(input bit v, input logic [7:0] b);
    @(negedge clk);
    op_valid = v;
    op_byte  = b;
    #1;
  endtask

  function automatic int quiet();
    return int'({rd_a, rd_b, wr_a, wr_b, ac_we, e_we, mem_we, zf_we, done});
  endfunction

  task automatic t_reset();
    chk_eq("R1 quiet in reset", quiet(), 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 8'h00);
    chk_eq("R1 quiet after reset", quiet(), 0);
    ports[2] = 4'h6;
    step(1'b1, 8'h02); // 0x02 is not a second byte: no pending after reset
    chk_eq("R1 no pending after reset", int'({done, rd_a, wr_a}), 3'b100);
  endtask

  task automatic t_in0();
    ports[0] = 4'h0;
    step(1'b1, 8'h20);
    chk_eq("R2 in0 strobe/idx", int'({rd_a, rd_a_idx, done}), {1'b1, 4'h0, 1'b1});
    chk_eq("R2 in0 ac data", int'({ac_we, ac_wdata}), {1'b1, 4'h0});
    chk_eq("R7 zf set on zero", int'({zf_we, zf}), 2'b11);
    ports[0] = 4'h9;
    step(1'b1, 8'h20);
    chk_eq("R2 in0 ac data 9", int'(ac_wdata), 9);
    chk_eq("R7 zf clear on nonzero", int'({zf_we, zf}), 2'b10);
  endtask

  task automatic t_indirect_in();
    dp_lo = 4'h7; ports[7] = 4'hA;
    step(1'b1, 8'h26);
    chk_eq("R3 ind ac", int'({rd_a, rd_a_idx, ac_we, ac_wdata}), {1'b1, 4'h7, 1'b1, 4'hA});
    chk_eq("R3 ind ac zf", int'({zf_we, zf, done}), 3'b101);
    dp_lo = 4'h3; ports[3] = 4'h0;
    step(1'b1, 8'h19);
    chk_eq("R3 ind mem", int'({rd_a, rd_a_idx, mem_we, mem_wdata}), {1'b1, 4'h3, 1'b1, 4'h0});
    chk_eq("R3 ind mem no ac/e", int'({ac_we, e_we}), 0);
    chk_eq("R8 mem input keeps zf", int'(zf_we), 0);
  endtask

  task automatic t_indirect_out();
    dp_lo = 4'hC; ac = 4'h5; mem_rd = 4'hE;
    step(1'b1, 8'h25);
    chk_eq("R4 out ac", int'({wr_a, wr_a_idx, wr_a_data}), {1'b1, 4'hC, 4'h5});
    chk_eq("R4 out ac no read", int'({rd_a, rd_b, wr_b}), 0);
    chk_eq("R8 out ac keeps zf", int'({zf_we, ac_we}), 0);
    step(1'b1, 8'h1A);
    chk_eq("R4 out mem", int'({wr_a, wr_a_idx, wr_a_data}), {1'b1, 4'hC, 4'hE});
    chk_eq("R8 out mem keeps zf", int'({zf_we, rd_a, done}), 3'b001);
  endtask

  task automatic t_direct();
    ports[15] = 4'h0; ports[2] = 4'h3; ac = 4'hB;
    step(1'b1, 8'hB4);
    chk_eq("R5 prefix quiet", quiet(), 0);
    step(1'b0, 8'h00);
    chk_eq("R10 stall quiet", quiet(), 0);
    step(1'b1, 8'h3F);
    chk_eq("R10 din after stall", int'({rd_a, rd_a_idx, done}), {1'b1, 4'hF, 1'b1});
    chk_eq("R5 din ac zf", int'({ac_we, ac_wdata, zf_we, zf}), {1'b1, 4'h0, 2'b11});
    step(1'b1, 8'hB4);
    step(1'b1, 8'hA2);
    chk_eq("R5 upper nibble ignored", int'({rd_a_idx, ac_wdata, zf}), {4'h2, 4'h3, 1'b0});
    step(1'b1, 8'hB5);
    chk_eq("R5 out prefix quiet", quiet(), 0);
    step(1'b1, 8'hE1);
    chk_eq("R5 dout", int'({wr_a, wr_a_idx, wr_a_data, done}), {1'b1, 4'h1, 4'hB, 1'b1});
    chk_eq("R8 dout keeps zf", int'({zf_we, rd_a}), 0);
  endtask

  task automatic t_pair();
    ports[4] = 4'hD; ports[5] = 4'h0; e_reg = 4'h7; ac = 4'h2;
    step(1'b1, 8'hF1);
    chk_eq("R6 pair prefix quiet", quiet(), 0);
    step(1'b1, 8'hBA);
    chk_eq("R6 pair in lanes", int'({rd_a, rd_a_idx, rd_b, rd_b_idx}), {1'b1, 4'h4, 1'b1, 4'h5});
    chk_eq("R6 pair in regs", int'({e_we, e_wdata, ac_we, ac_wdata}), {1'b1, 4'hD, 1'b1, 4'h0});
    chk_eq("R7 pair in zf", int'({zf_we, zf, done}), 3'b111);
    step(1'b1, 8'hF1);
    step(1'b1, 8'hBB);
    chk_eq("R6 pair out A", int'({wr_a, wr_a_idx, wr_a_data}), {1'b1, 4'h4, 4'h7});
    chk_eq("R6 pair out B", int'({wr_b, wr_b_idx, wr_b_data}), {1'b1, 4'h5, 4'h2});
    chk_eq("R11 pair out no read", int'({rd_a, rd_b, zf_we}), 0);
    step(1'b1, 8'hF1);
    step(1'b1, 8'h20);
    chk_eq("R9 bad pair second byte", quiet(), 1);
  endtask

  task automatic t_misc();
    step(1'b1, 8'h00);
    chk_eq("R9 unknown opcode no effect", quiet(), 1);
    step(1'b0, 8'h20);
    chk_eq("R9 idle no done", quiet(), 0);
    dp_lo = 4'h9; ports[9] = 4'h1;
    step(1'b1, 8'h26);
    chk_eq("R11 single-byte lane B idle", int'({rd_b, wr_b, rd_a}), 3'b001);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ports[i] = 4'(i);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_in0();
    t_indirect_in();
    t_indirect_out();
    t_direct();
    t_pair();
    t_misc();
    step(1'b0, 8'h00);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule